// File: doc/BRIEF.md
# SIMD Warp Issue Scheduler

This block drives a row of identical execution lanes from a pool of warp contexts. A warp is a group of threads that all run the same instruction. The lane row is narrower than a warp, so each warp instruction is issued over several consecutive beats. In each beat a fixed slice of the warp's threads is mapped onto the lanes, and each lane is enabled only when its thread is active in that warp's thread mask.

At every instruction boundary the scheduler may switch to another warp. It picks round-robin among the warps that report ready, starting just after the last warp it issued. A warp that is waiting on memory simply drops its ready bit and is skipped, so other warps hide its latency. With the defaults there are 24 contexts, 32 threads per warp and 8 lanes, which gives 4 beats per instruction.

Top module: `warp_issue_sched`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset, issue_valid_o is 0, lane_en_o is 0 and beat_o is 0.
- R2: Each selected warp is issued for exactly WARP_SIZE/NUM_LANES consecutive cycles. beat_o counts 0,1,2,3 and warp_o holds the same value throughout, with issue_valid_o high.
- R3: In beat b, lane l serves thread b*NUM_LANES+l. That thread index appears on thread_o[l*5 +: 5].
- R4: In beat b, lane_en_o[l] equals bit (warp_o*32 + b*8 + l) of mask_i, where warp w owns mask_i[w*32 +: 32]. Masked-off threads still take up their beat.
- R5: A new warp is chosen only in the cycle after beat 3 (or while idle). The choice is the first warp with ready_i set, scanning upward from the last issued warp plus one. After reset the scan starts at warp 0.
- R6: If no warp is ready at a boundary, issue_valid_o and lane_en_o are 0 for that cycle, and selection is tried again on every following cycle.
- R7: ready_i is looked at only at selection time. Clearing a warp's ready bit during its beats does not shorten its instruction.
- R8: The round-robin scan wraps from the highest warp index (23) back to warp 0.
- R9: A warp whose mask is all zero still takes four beats with issue_valid_o high and every lane disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ready_i | input | NUM_WARPS | Per-warp ready bits |
| mask_i | input | NUM_WARPS*WARP_SIZE | Per-warp active-thread masks, warp w at [w*WARP_SIZE +: WARP_SIZE] |
| issue_valid_o | output | 1 | A warp instruction beat is on the lanes |
| warp_o | output | $clog2(NUM_WARPS) | Index of the warp being issued |
| beat_o | output | $clog2(WARP_SIZE/NUM_LANES) | Sub-cycle number inside the instruction |
| thread_o | output | NUM_LANES*$clog2(WARP_SIZE) | Thread index served by each lane |
| lane_en_o | output | NUM_LANES | Per-lane enable |

## Verification
The bench drops a warp's ready bit right after it is picked. A design that rechecked ready on every beat would cut that instruction short, and the bench sees this as a missing beat. It sets ready bits on both sides of the last issued warp and at indices 0 and 23. A scheduler with fixed priority, or one that did not wrap, would then issue in the wrong order. An all-zero mask and a stretch with no warp ready separate "issuing with no lanes enabled" from "idle": the first keeps issue_valid_o high for four beats, the second must keep it low. A design that left stale enables on the lanes while idle would fail the second case.

// File: rtl/wis_pkg.sv
package wis_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } issue_st_e;
endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int NUM_WARPS = 24,
  localparam int WID = $clog2(NUM_WARPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WARPS-1:0] req_i,
  input  logic [WID-1:0]       last_i,
  output logic                 found_o,
  output logic [WID-1:0]       idx_o
);
  logic [WID:0] cand;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    cand    = '0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      cand = {1'b0, last_i} + (WID+1)'(k);
      if (cand >= (WID+1)'(NUM_WARPS)) cand = cand - (WID+1)'(NUM_WARPS);
      if (!found_o && req_i[cand[WID-1:0]]) begin
        found_o = 1'b1;
        idx_o   = cand[WID-1:0];
      end
    end
  end

  // R5
  pick_is_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> req_i[idx_o]);
  // R6
  pick_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> !found_o);
endmodule

// File: rtl/wis_beat_ctrl.sv
module wis_beat_ctrl
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int BEATS     = 4,
  localparam int WID = $clog2(NUM_WARPS),
  localparam int BW  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pick_found_i,
  input  logic [WID-1:0] pick_idx_i,
  output logic           boundary_o,
  output logic           busy_o,
  output logic [WID-1:0] warp_o,
  output logic [BW-1:0]  beat_o,
  output logic [WID-1:0] last_o
);
  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

  issue_st_e st_q;
  logic [WID-1:0] warp_q;
  logic [BW-1:0]  beat_q;

  assign boundary_o = (st_q == ST_IDLE) || (beat_q == LAST_BEAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      warp_q <= WID'(NUM_WARPS - 1);
      beat_q <= '0;
    end else if (boundary_o) begin
      beat_q <= '0;
      if (pick_found_i) begin
        st_q   <= ST_BUSY;
        warp_q <= pick_idx_i;
      end else begin
        st_q   <= ST_IDLE;
      end
    end else begin
      beat_q <= beat_q + BW'(1);
    end
  end

  assign busy_o = (st_q == ST_BUSY);
  assign warp_o = warp_q;
  assign beat_o = beat_q;
  assign last_o = warp_q;

  // R2
  beat_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && beat_o != LAST_BEAT) |=> (busy_o && beat_o == $past(beat_o) + BW'(1)));
  // R7
  warp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && beat_o != LAST_BEAT) |=> $stable(warp_o));
  // R5
  start_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (beat_o == '0));
  // R6
  idle_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (beat_o == '0));
endmodule

// File: rtl/wis_lane_map.sv
module wis_lane_map #(
  parameter int NUM_WARPS = 24,
  parameter int WARP_SIZE = 32,
  parameter int NUM_LANES = 8,
  localparam int WID = $clog2(NUM_WARPS),
  localparam int BEATS = WARP_SIZE / NUM_LANES,
  localparam int BW  = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int TW  = $clog2(WARP_SIZE),
  localparam int MW  = $clog2(NUM_WARPS * WARP_SIZE)
) (
  input  logic                           busy_i,
  input  logic [WID-1:0]                 warp_i,
  input  logic [BW-1:0]                  beat_i,
  input  logic [NUM_WARPS*WARP_SIZE-1:0] mask_i,
  output logic [NUM_LANES*TW-1:0]        thread_o,
  output logic [NUM_LANES-1:0]           lane_en_o
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [TW-1:0] thr;
    logic [MW-1:0] bit_idx;
    always_comb begin
      thr     = TW'(int'(beat_i) * NUM_LANES + l);
      bit_idx = MW'(int'(warp_i) * WARP_SIZE + int'(thr));
    end
    assign thread_o[l*TW +: TW] = thr;
    assign lane_en_o[l]         = busy_i & mask_i[bit_idx];
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 24,
  parameter int WARP_SIZE = 32,
  parameter int NUM_LANES = 8,
  localparam int WID   = $clog2(NUM_WARPS),
  localparam int BEATS = WARP_SIZE / NUM_LANES,
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int TW    = $clog2(WARP_SIZE)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_WARPS-1:0]           ready_i,
  input  logic [NUM_WARPS*WARP_SIZE-1:0] mask_i,
  output logic                           issue_valid_o,
  output logic [WID-1:0]                 warp_o,
  output logic [BW-1:0]                  beat_o,
  output logic [NUM_LANES*TW-1:0]        thread_o,
  output logic [NUM_LANES-1:0]           lane_en_o
);
  logic           found, boundary, busy;
  logic [WID-1:0] pick_idx, last_warp;

  wis_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (ready_i),
    .last_i  (last_warp),
    .found_o (found),
    .idx_o   (pick_idx)
  );

  wis_beat_ctrl #(.NUM_WARPS(NUM_WARPS), .BEATS(BEATS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pick_found_i (found),
    .pick_idx_i   (pick_idx),
    .boundary_o   (boundary),
    .busy_o       (busy),
    .warp_o       (warp_o),
    .beat_o       (beat_o),
    .last_o       (last_warp)
  );

  wis_lane_map #(.NUM_WARPS(NUM_WARPS), .WARP_SIZE(WARP_SIZE), .NUM_LANES(NUM_LANES)) u_map (
    .busy_i    (busy),
    .warp_i    (warp_o),
    .beat_i    (beat_o),
    .mask_i    (mask_i),
    .thread_o  (thread_o),
    .lane_en_o (lane_en_o)
  );

  assign issue_valid_o = busy;

  // R6
  idle_lanes_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_o |-> (lane_en_o == '0));
  // R5
  switch_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !boundary) |=> (issue_valid_o && $stable(warp_o)));
  // R3
  lane0_thread_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thread_o[TW-1:0] == TW'(int'(beat_o) * NUM_LANES));
endmodule

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;
  localparam int NW = 24, WS = 32, NL = 8, TW = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NW-1:0]  ready = '0;
  logic [31:0]    masks [NW];
  logic [NW*WS-1:0] mask_flat;
  logic           valid;
  logic [4:0]     warp;
  logic [1:0]     beat;
  logic [NL*TW-1:0] thread;
  logic [NL-1:0]  lane_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb
    for (int w = 0; w < NW; w++) mask_flat[w*WS +: WS] = masks[w];

  warp_issue_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ready_i(ready), .mask_i(mask_flat),
    .issue_valid_o(valid), .warp_o(warp), .beat_o(beat),
    .thread_o(thread), .lane_en_o(lane_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // call at a negedge where beat 0 of the instruction is visible
  task automatic expect_instr(input int w, input string req);
    for (int b = 0; b < 4; b++) begin
      chk({req, " R2 valid"}, 64'(valid), 64'd1);
      chk({req, " R2 warp"}, 64'(warp), 64'(w));
      chk({req, " R2 beat"}, 64'(beat), 64'(b));
      chk({req, " R4 lane_en"}, 64'(lane_en), 64'(masks[w][b*8 +: 8]));
      for (int l = 0; l < NL; l++)
        chk({req, " R3 thread"}, 64'(thread[l*TW +: TW]), 64'(b*8 + l));
      @(negedge clk);
    end
  endtask

  task automatic expect_idle(input string req);
    chk({req, " R6 valid"}, 64'(valid), 64'd0);
    chk({req, " R6 lane_en"}, 64'(lane_en), 64'd0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 valid", 64'(valid), 64'd0);
    chk("R1 lane_en", 64'(lane_en), 64'd0);
    chk("R1 beat", 64'(beat), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post valid", 64'(valid), 64'd0);
    chk("R1 post lane_en", 64'(lane_en), 64'd0);
    repeat (2) begin @(negedge clk); expect_idle("R6 none_ready"); end
  endtask

  // R7: ready dropped right after selection, instruction still runs 4 beats
  task automatic t_single_drop();
    ready[5] = 1'b1;
    @(negedge clk);
    ready[5] = 1'b0;
    expect_instr(5, "R7");
    expect_idle("R7 after");
  endtask

  // R5: round robin from last issued (5)
  task automatic t_round_robin();
    ready = '0; ready[2] = 1'b1; ready[9] = 1'b1; ready[17] = 1'b1;
    @(negedge clk);
    expect_instr(9, "R5 first");
    expect_instr(17, "R5 second");
    expect_instr(2, "R5 third");
    ready = '0;
    expect_instr(9, "R5 fourth");
    expect_idle("R6 drained");
  endtask

  // R8: wrap from 23 to 0
  task automatic t_wrap();
    ready = '0; ready[0] = 1'b1; ready[23] = 1'b1;
    @(negedge clk);
    expect_instr(23, "R8 high");
    expect_instr(0, "R8 wrap");
    ready = '0;
    expect_instr(23, "R8 again");
    expect_idle("R8 end");
  endtask

  // R9: empty mask still occupies four beats
  task automatic t_zero_mask();
    ready = '0; ready[7] = 1'b1;
    @(negedge clk);
    ready = '0;
    expect_instr(7, "R9");
    expect_idle("R9 end");
  endtask

  initial begin
    for (int w = 0; w < NW; w++)
      masks[w] = 32'hA5C3_0F69 ^ (32'(w) * 32'h0111_1011);
    masks[7] = '0;
    @(negedge clk);
    t_reset();
    t_single_drop();
    t_round_robin();
    t_wrap();
    t_zero_mask();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule